// File: doc/BRIEF.md
# Sub-page Spare Repacker and Error Tracker

This block takes in one large flash page as four back-to-back sub-page byte streams of 528 bytes each. In every sub-page it sends the first 512 bytes to a 2048-byte data buffer. It sends the 16 trailing spare bytes to a 64-byte spare buffer in a packed arrangement: the six free bytes of all four sub-pages come first, and all forty check bytes come after them. The two buffers sit outside the block and are written through two plain write ports, each one byte wide.

An upstream error-correcting decoder gives one status word per sub-page. The block reduces these four words to a single page result. The result is the largest corrected-error count seen in any sub-page, or a failure flag. Two modes exist. In full-page mode, an uncorrectable sub-page ends the page at once with a failure. In spare-only mode, the data bytes are dropped, an uncorrectable sub-page is reported as a count of five, and the page runs to its end.

The input is a valid/ready byte stream. The block lowers `in_ready` for exactly one cycle, the cycle after the final byte of a page has been accepted, so that the error tracker can restart. `in_ready` is high at every other time. The upstream source may insert gaps by lowering `in_valid` at any point. A byte is taken only when `in_valid` and `in_ready` are both high on a rising edge.

Top module: `subpage_repacker`

## Requirements
- R1: Stream byte j (0..511) of sub-page i is written to data address 512*i+j, in the cycle after it is accepted.
- R2: Stream bytes 512..517 of sub-page i are written to spare address 6*i+(j-512).
- R3: Stream bytes 518..527 of sub-page i are written to spare address 24+10*i+(j-518).
- R4: `dec_status` is sampled together with the last byte of each sub-page. Bit 6 set means the sub-page is uncorrectable, and it takes precedence over the other bits. Otherwise, bit 3 set means bits [5:4]+1 errors were corrected. With bits 3 and 6 both clear, the sub-page counts zero errors, whatever bits [5:4] hold.
- R5: In full-page mode, an uncorrectable sub-page ends the page with `page_fail`=1 and `page_errs` equal to the largest count among the earlier sub-pages. The next accepted byte is sub-page 0, byte 0 of a new page.
- R6: `page_errs` is the maximum of the per-sub-page counts, not their sum.
- R7: `oob_only` is sampled on the first byte of a page. When it is 1, no data-buffer write occurs for that page, an uncorrectable sub-page sets the count to 5, all four sub-pages are processed, and `page_fail` stays 0.
- R8: `page_done` is a one-cycle pulse. It rises two cycles after the final byte of a page is accepted, which is one cycle after that byte's buffer write, and it carries `page_errs` and `page_fail`.
- R9: `in_ready` is low only in the cycle after a page's final byte is accepted. No buffer write appears in a cycle that follows an edge with no accepted byte.
- R10: After reset, `in_ready` is 1 and `page_done`, `page_fail`, `page_errs`, `data_we` and `oob_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oob_only | input | 1 | Spare-only mode, sampled on the first byte of a page |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte can be taken |
| in_byte | input | 8 | Stream byte |
| dec_status | input | 8 | Decoder status for the current sub-page, used with its last byte |
| data_we | output | 1 | Data buffer write strobe |
| data_addr | output | 11 | Data buffer address |
| data_wdata | output | 8 | Data buffer write byte |
| oob_we | output | 1 | Spare buffer write strobe |
| oob_addr | output | 6 | Spare buffer address |
| oob_wdata | output | 8 | Spare buffer write byte |
| page_done | output | 1 | Page result pulse |
| page_errs | output | 3 | Page maximum corrected-error count (5 marks uncorrectable in spare-only mode) |
| page_fail | output | 1 | Page failed (full-page mode only) |

## Verification
A wrong byte counter shows up within one sub-page as a misplaced byte in one of the buffers. It also moves the page end, so `page_done` comes early or late, or the next page is shifted. A tracker that sums counts or misreads the status fields is visible only at the `page_done` pulse. For that reason the directed pages use distinct status mixes whose maximum and sum differ. A stale mode latch appears as stray data writes in spare-only pages, or as a failure where a count of five was due. A bad abort path shows up as a missing early pulse and as a misplaced next page.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int unsigned CNT_W        = 3;
  localparam int unsigned ST_CORR_BIT  = 3;
  localparam int unsigned ST_CNT_LSB   = 4;
  localparam int unsigned ST_FAIL_BIT  = 6;
  localparam logic [CNT_W-1:0] FAIL_COUNT = 3'd5;

  typedef struct packed {
    logic             fail;
    logic [CNT_W-1:0] cnt;
  } sub_verdict_t;

  function automatic sub_verdict_t decode_status(input logic [7:0] st);
    sub_verdict_t v;
    v.fail = 1'b0;
    v.cnt  = '0;
    if (st[ST_FAIL_BIT]) begin
      v.fail = 1'b1;
    end else if (st[ST_CORR_BIT]) begin
      v.cnt = {1'b0, st[ST_CNT_LSB+1:ST_CNT_LSB]} + 3'd1;
    end
    return v;
  endfunction

endpackage

// File: rtl/spr_stream_counter.sv
module spr_stream_counter #(
  parameter int unsigned SUBPAGES  = 4,
  parameter int unsigned SUB_BYTES = 528,
  localparam int unsigned SUB_W  = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1,
  localparam int unsigned BYTE_W = $clog2(SUB_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  output logic [SUB_W-1:0]  sub_idx,
  output logic [BYTE_W-1:0] byte_idx,
  output logic              last_byte,
  output logic              last_sub,
  output logic              at_start
);

  logic [SUB_W-1:0]  sub_q;
  logic [BYTE_W-1:0] byte_q;

  assign sub_idx   = sub_q;
  assign byte_idx  = byte_q;
  assign last_byte = (byte_q == BYTE_W'(SUB_BYTES - 1));
  assign last_sub  = (sub_q == SUB_W'(SUBPAGES - 1));
  assign at_start  = (sub_q == '0) && (byte_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      byte_q <= '0;
    end else if (step && restart) begin
      sub_q  <= '0;
      byte_q <= '0;
    end else if (step) begin
      if (last_byte) begin
        byte_q <= '0;
        sub_q  <= last_sub ? '0 : sub_q + 1'b1;
      end else begin
        byte_q <= byte_q + 1'b1;
      end
    end
  end

  AST_ABORT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && restart) |=> at_start) else $error("abort did not rewind"); // R5

endmodule

// File: rtl/spr_byte_router.sv
module spr_byte_router #(
  parameter int unsigned SUBPAGES   = 4,
  parameter int unsigned DATA_BYTES = 512,
  parameter int unsigned FREE_BYTES = 6,
  parameter int unsigned ECC_BYTES  = 10,
  localparam int unsigned SUB_BYTES = DATA_BYTES + FREE_BYTES + ECC_BYTES,
  localparam int unsigned SUB_W     = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1,
  localparam int unsigned BYTE_W    = $clog2(SUB_BYTES),
  localparam int unsigned DA_W      = $clog2(SUBPAGES * DATA_BYTES),
  localparam int unsigned OA_W      = $clog2(SUBPAGES * (FREE_BYTES + ECC_BYTES))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              skip_data,
  input  logic [SUB_W-1:0]  sub_idx,
  input  logic [BYTE_W-1:0] byte_idx,
  input  logic [7:0]        byte_in,
  output logic              data_we,
  output logic [DA_W-1:0]   data_addr,
  output logic [7:0]        data_wdata,
  output logic              oob_we,
  output logic [OA_W-1:0]   oob_addr,
  output logic [7:0]        oob_wdata
);

  localparam int unsigned FREE_REGION = SUBPAGES * FREE_BYTES;
  localparam int unsigned CHECK_START = DATA_BYTES + FREE_BYTES;

  logic            in_data, in_free;
  logic [DA_W-1:0] data_addr_c;
  logic [OA_W-1:0] free_addr_c, ecc_addr_c;

  always_comb begin
    in_data     = byte_idx < BYTE_W'(DATA_BYTES);
    in_free     = !in_data && (byte_idx < BYTE_W'(CHECK_START));
    data_addr_c = DA_W'(sub_idx) * DA_W'(DATA_BYTES) + DA_W'(byte_idx);
    free_addr_c = OA_W'(sub_idx) * OA_W'(FREE_BYTES)
                + OA_W'(byte_idx - BYTE_W'(DATA_BYTES));
    ecc_addr_c  = OA_W'(FREE_REGION) + OA_W'(sub_idx) * OA_W'(ECC_BYTES)
                + OA_W'(byte_idx - BYTE_W'(CHECK_START));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_we    <= 1'b0;
      data_addr  <= '0;
      data_wdata <= '0;
      oob_we     <= 1'b0;
      oob_addr   <= '0;
      oob_wdata  <= '0;
    end else begin
      data_we <= accept && in_data && !skip_data;
      oob_we  <= accept && !in_data;
      if (accept && in_data) begin
        data_addr  <= data_addr_c;
        data_wdata <= byte_in;
      end
      if (accept && !in_data) begin
        oob_addr  <= in_free ? free_addr_c : ecc_addr_c;
        oob_wdata <= byte_in;
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_we && oob_we)) else $error("byte sent to both buffers"); // R1

  AST_FREE_BEFORE_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_free) |=> (oob_we && oob_addr < OA_W'(FREE_REGION)))
    else $error("free byte outside free region"); // R2

endmodule

// File: rtl/spr_err_tracker.sv
module spr_err_tracker
  import spr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_end,
  input  logic [7:0]       status,
  input  logic             spare_mode,
  input  logic             clear,
  output logic             abort,
  output logic [CNT_W-1:0] max_cnt,
  output logic             fail_flag
);

  sub_verdict_t verdict;

  always_comb begin
    verdict = decode_status(status);
    abort   = sub_end && verdict.fail && !spare_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_cnt   <= '0;
      fail_flag <= 1'b0;
    end else if (clear) begin
      max_cnt   <= '0;
      fail_flag <= 1'b0;
    end else if (sub_end) begin
      if (verdict.fail) begin
        if (spare_mode) max_cnt <= FAIL_COUNT;
        else            fail_flag <= 1'b1;
      end else if (verdict.cnt > max_cnt) begin
        max_cnt <= verdict.cnt;
      end
    end
  end

  AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear) |-> max_cnt >= $past(max_cnt)) else $error("max fell"); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    max_cnt <= FAIL_COUNT) else $error("count above five"); // R4

  AST_FAIL_NORMAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag |-> !spare_mode) else $error("fail in spare mode"); // R7

endmodule

// File: rtl/subpage_repacker.sv
module subpage_repacker
  import spr_pkg::*;
#(
  parameter int unsigned SUBPAGES   = 4,
  parameter int unsigned DATA_BYTES = 512,
  parameter int unsigned FREE_BYTES = 6,
  parameter int unsigned ECC_BYTES  = 10,
  localparam int unsigned SUB_BYTES = DATA_BYTES + FREE_BYTES + ECC_BYTES,
  localparam int unsigned SUB_W     = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1,
  localparam int unsigned BYTE_W    = $clog2(SUB_BYTES),
  localparam int unsigned DA_W      = $clog2(SUBPAGES * DATA_BYTES),
  localparam int unsigned OA_W      = $clog2(SUBPAGES * (FREE_BYTES + ECC_BYTES))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oob_only,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  input  logic [7:0]       dec_status,
  output logic             data_we,
  output logic [DA_W-1:0]  data_addr,
  output logic [7:0]       data_wdata,
  output logic             oob_we,
  output logic [OA_W-1:0]  oob_addr,
  output logic [7:0]       oob_wdata,
  output logic             page_done,
  output logic [CNT_W-1:0] page_errs,
  output logic             page_fail
);

  logic              accept, end_q, mode_q, mode_eff;
  logic [SUB_W-1:0]  sub_idx;
  logic [BYTE_W-1:0] byte_idx;
  logic              last_byte, last_sub, at_start;
  logic              sub_end, abort, page_end;
  logic [CNT_W-1:0]  max_cnt;
  logic              fail_flag;

  assign in_ready = !end_q;
  assign accept   = in_valid && in_ready;
  assign mode_eff = at_start ? oob_only : mode_q;
  assign sub_end  = accept && last_byte;
  assign page_end = sub_end && (last_sub || abort);

  spr_stream_counter #(.SUBPAGES(SUBPAGES), .SUB_BYTES(SUB_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(accept), .restart(abort),
    .sub_idx(sub_idx), .byte_idx(byte_idx), .last_byte(last_byte),
    .last_sub(last_sub), .at_start(at_start)
  );

  spr_byte_router #(
    .SUBPAGES(SUBPAGES), .DATA_BYTES(DATA_BYTES),
    .FREE_BYTES(FREE_BYTES), .ECC_BYTES(ECC_BYTES)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .accept(accept), .skip_data(mode_eff),
    .sub_idx(sub_idx), .byte_idx(byte_idx), .byte_in(in_byte),
    .data_we(data_we), .data_addr(data_addr), .data_wdata(data_wdata),
    .oob_we(oob_we), .oob_addr(oob_addr), .oob_wdata(oob_wdata)
  );

  spr_err_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .sub_end(sub_end), .status(dec_status),
    .spare_mode(mode_q), .clear(end_q), .abort(abort),
    .max_cnt(max_cnt), .fail_flag(fail_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      end_q     <= 1'b0;
      page_done <= 1'b0;
      page_errs <= '0;
      page_fail <= 1'b0;
    end else begin
      if (accept && at_start) mode_q <= oob_only;
      end_q     <= page_end;
      page_done <= end_q;
      if (end_q) begin
        page_errs <= max_cnt;
        page_fail <= fail_flag;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !page_done) else $error("done longer than one cycle"); // R8

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !(data_we || oob_we)) else $error("write without accept"); // R9

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> in_ready) else $error("ready low at done"); // R9

  AST_SPARE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |-> !mode_q) else $error("data write in spare-only mode"); // R7

endmodule

// File: tb/subpage_repacker_bench.sv
`timescale 1ns/1ps
module subpage_repacker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oob_only = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = '0;
  logic [7:0] dec_status = '0;
  logic       data_we, oob_we, page_done, page_fail;
  logic [10:0] data_addr;
  logic [5:0]  oob_addr;
  logic [7:0]  data_wdata, oob_wdata;
  logic [2:0]  page_errs;

  always #2.5 clk = ~clk;

  subpage_repacker u_subpage_repacker (
    .clk(clk), .rst_n(rst_n), .oob_only(oob_only), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .dec_status(dec_status),
    .data_we(data_we), .data_addr(data_addr), .data_wdata(data_wdata),
    .oob_we(oob_we), .oob_addr(oob_addr), .oob_wdata(oob_wdata),
    .page_done(page_done), .page_errs(page_errs), .page_fail(page_fail)
  );

  int checks = 0;
  int fails  = 0;
  int nd = 0;
  int no = 0;
  int cycles = 0;
  logic [7:0] got_data [2048];
  logic [7:0] got_oob  [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (data_we) begin got_data[data_addr] = data_wdata; nd++; end
    if (oob_we)  begin got_oob[oob_addr]   = oob_wdata;  no++; end
    if (cycles > 150000) begin
      chk(1'b0, "R8", "watchdog expired", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int s, input int b);
    return 8'(seed * 13 + s * 59 + b * 7 + (b >> 4));
  endfunction

  task automatic push(input logic [7:0] b, input logic [7:0] st,
                      input bit mode, input bit bubble);
    @(negedge clk);
    if (bubble) begin
      in_valid = 1'b0;
      @(negedge clk);
      chk(!data_we && !oob_we, "R9", "write during gap", int'(data_we | oob_we), 0);
    end
    in_valid = 1'b1; in_byte = b; dec_status = st; oob_only = mode;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_page(input string tag, input int seed, input bit mode,
                          input logic [31:0] sts, input int nsub, input bit gap,
                          input int exp_errs, input int exp_fail,
                          input int exp_nd, input int exp_no);
    int bad_d, bad_f, bad_e;
    @(posedge clk);
    nd = 0; no = 0;
    for (int s = 0; s < nsub; s++)
      for (int b = 0; b < 528; b++)
        push(pat(seed, s, b), sts[8*s +: 8], mode, gap && (b % 97 == 50));
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R9", "ready after last byte", int'(in_ready), 0);
    chk(!page_done, "R8", "done too early", int'(page_done), 0);
    @(negedge clk);
    chk(page_done, "R8", "done pulse", int'(page_done), 1);
    chk(int'(page_errs) == exp_errs, tag, "page_errs", int'(page_errs), exp_errs);
    chk(int'(page_fail) == exp_fail, tag, "page_fail", int'(page_fail), exp_fail);
    @(negedge clk);
    chk(!page_done && in_ready, "R8", "pulse end / ready back",
        int'(page_done) * 2 + int'(!in_ready), 0);
    chk(nd == exp_nd, mode ? "R7" : "R1", "data write count", nd, exp_nd);
    chk(no == exp_no, "R2", "spare write count", no, exp_no);
    bad_d = 0; bad_f = 0; bad_e = 0;
    for (int s = 0; s < nsub; s++)
      for (int b = 0; b < 528; b++) begin
        if (b < 512) begin
          if (!mode && got_data[512*s + b] !== pat(seed, s, b)) bad_d++;
        end else if (b < 518) begin
          if (got_oob[6*s + b - 512] !== pat(seed, s, b)) bad_f++;
        end else begin
          if (got_oob[24 + 10*s + b - 518] !== pat(seed, s, b)) bad_e++;
        end
      end
    chk(bad_d == 0, "R1", "data layout mismatches", bad_d, 0);
    chk(bad_f == 0, "R2", "free layout mismatches", bad_f, 0);
    chk(bad_e == 0, "R3", "check layout mismatches", bad_e, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !page_done && !page_fail && page_errs == 0 && !data_we && !oob_we,
        "R10", "reset state", int'(in_ready), 1);
  endtask

  task automatic t_clean;
    run_page("R4", 1, 1'b0, 32'h0000_0000, 4, 1'b0, 0, 0, 2048, 64);
  endtask

  task automatic t_max_not_sum;
    // counts 1,4,2,0 : max 4, sum would be 7
    run_page("R6", 2, 1'b0, 32'h0018_3808, 4, 1'b0, 4, 0, 2048, 64);
  endtask

  task automatic t_count_field_ignored;
    run_page("R4", 3, 1'b0, 32'h3030_3030, 4, 1'b0, 0, 0, 2048, 64);
  endtask

  task automatic t_abort;
    // sub0 3 errors, sub1 uncorrectable: page ends after sub1
    run_page("R5", 4, 1'b0, 32'h0000_4028, 2, 1'b0, 3, 1, 1024, 32);
  endtask

  task automatic t_abort_first_precedence;
    // bit6 with bit3 on sub0 in full-page mode
    run_page("R5", 5, 1'b0, 32'h0000_0078, 1, 1'b0, 0, 1, 512, 16);
  endtask

  task automatic t_gaps_after_abort;
    run_page("R9", 6, 1'b0, 32'h0808_0808, 4, 1'b1, 1, 0, 2048, 64);
  endtask

  task automatic t_spare_uncorrectable;
    run_page("R7", 7, 1'b1, 32'h0878_4018, 4, 1'b0, 5, 0, 0, 64);
  endtask

  task automatic t_spare_clean;
    run_page("R7", 8, 1'b1, 32'h0000_2800, 4, 1'b0, 3, 0, 0, 64);
  endtask

  task automatic t_mode_back;
    run_page("R6", 9, 1'b0, 32'h2818_0838, 4, 1'b0, 4, 0, 2048, 64);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_max_not_sum();
    t_count_field_ignored();
    t_abort();
    t_abort_first_precedence();
    t_gaps_after_abort();
    t_spare_uncorrectable();
    t_spare_clean();
    t_mode_back();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule